// File: doc/BRIEF.md
# Password Retry Lockout Unit

This unit counts failed password attempts and decides how far access is shut off once too many have been made. Software-visible state consists of an 8-bit configuration register and an attempt-limit register, each with its own write port and a read-back output. A failure counter sits alongside them. The surrounding protocol logic reads the lockout level before it evaluates a password. It then reports the outcome as a one-cycle result strobe with a pass/fail flag.

The level is computed combinationally from the registers, so it always reflects the current counter and limit. There are three levels. "none" lets the protocol continue. "configuration-only" permits configuration operations only. "total" forbids every kind of access. A two-bit severity field in the configuration register chooses between the two lockout levels. A separate clear-on-success bit decides whether a correct password wipes the failure count. Password comparison, non-volatile storage and the bus protocol sit outside this unit.

Top module: `pwd_retry_lockout`

## Requirements
- R1: The configuration read-back is {SEV1, SEV0, 1, 0, CLR, EN, 0, 0} from bit 7 down to bit 0. A write stores only bits 7, 6, 3 and 2, and the other positions always read back fixed. After reset the register reads 8'h20.
- R2: The limit register reads back the last value written to it. After reset the limit and the failure counter are both 0.
- R3: When EN (bit 2) is 0, the lockout level is always none, and pass or fail results leave the counter unchanged.
- R4: When EN is 1, the counter is at or above the limit, and {SEV1,SEV0} = 2'b10, the level is total.
- R5: When EN is 1, the counter is at or above the limit, and {SEV1,SEV0} is 2'b00, 2'b01 or 2'b11, the level is configuration-only.
- R6: A fail result while EN is 1 and the level is none raises the counter by exactly one, on the clock edge that samples the result.
- R7: A pass result while EN is 1 and the level is none clears the counter when CLR (bit 3) is 1. It leaves the counter unchanged when CLR is 0.
- R8: A result while the level is not none changes nothing. Without a result the counter holds its value. The counter therefore saturates at the limit and never wraps.
- R9: The lockout level is encoded as 2'd0 none, 2'd1 configuration-only and 2'd2 total. The value 2'd3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 8 | Limit write data |
| lim_rdata | output | 8 | Limit read-back |
| res_valid | input | 1 | One-cycle password result strobe |
| res_pass | input | 1 | Result flag, 1 = correct password |
| fail_cnt | output | 8 | Current failure count |
| lock_lvl | output | 2 | Lockout level: 0 none, 1 configuration-only, 2 total |

## Verification
The embedded properties assume that every result strobe lasts one cycle, with the pass flag valid alongside it. They also assume that a result is only meaningful in a cycle where the level was sampled just before the edge. The bench keeps to this: it drives each strobe, register write or result for exactly one clock, and it returns the inputs to idle before checking. The sweep covers every severity code, both clear-on-success settings, both enable settings and small limits. Fail runs extend past the limit to reach saturation, and the limit is lowered beneath an existing count to confirm that "at or above" locks.

// File: rtl/prl_pkg.sv
package prl_pkg;

    typedef enum logic [1:0] {
        LOCK_NONE = 2'd0,
        LOCK_CFG  = 2'd1,
        LOCK_ALL  = 2'd2
    } lock_lvl_e;

    typedef struct packed {
        logic sev1;
        logic sev0;
        logic clr;
        logic en;
    } cfg_fields_t;

    localparam logic [7:0] CFG_FIXED_ONES = 8'h20;
    localparam logic [7:0] CFG_KEEP_MASK  = 8'hCC;

endpackage

// File: rtl/prl_regs.sv
module prl_regs
    import prl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] lim_wdata,
    output cfg_fields_t      cfg,
    output logic [7:0]       cfg_rdata,
    output logic [CNT_W-1:0] lim
);

    typedef struct packed {
        cfg_fields_t      cfg;
        logic [CNT_W-1:0] lim;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg.sev1 = cfg_wdata[7];
            st_d.cfg.sev0 = cfg_wdata[6];
            st_d.cfg.clr  = cfg_wdata[3];
            st_d.cfg.en   = cfg_wdata[2];
        end
        if (lim_we) begin
            st_d.lim = lim_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg       = st_q.cfg;
    assign lim       = st_q.lim;
    assign cfg_rdata = {st_q.cfg.sev1, st_q.cfg.sev0, 2'b10,
                        st_q.cfg.clr, st_q.cfg.en, 2'b00};

    // R1: a write keeps only the live bits; the fixed pattern shows through
    assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == (($past(cfg_wdata) & CFG_KEEP_MASK) | CFG_FIXED_ONES));

    // R2: limit read-back follows the last write
    assert_lim_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we |=> lim == $past(lim_wdata));

    // R2: without a write the limit holds
    assert_lim_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_we |=> $stable(lim));

endmodule

// File: rtl/prl_lock_decode.sv
module prl_lock_decode
    import prl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  cfg_fields_t      cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lim,
    output lock_lvl_e        lvl
);

    logic reached;

    always_comb begin
        reached = cfg.en && (cnt >= lim);
        if (!reached) begin
            lvl = LOCK_NONE;
        end else if ({cfg.sev1, cfg.sev0} == 2'b10) begin
            lvl = LOCK_ALL;
        end else begin
            lvl = LOCK_CFG;
        end
    end

endmodule

// File: rtl/prl_fail_counter.sv
module prl_fail_counter
    import prl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_fields_t      cfg,
    input  logic [CNT_W-1:0] lim,
    input  lock_lvl_e        lvl,
    input  logic             res_valid,
    input  logic             res_pass,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = res_valid && cfg.en && (lvl == LOCK_NONE);
        if (accept) begin
            if (!res_pass) begin
                if (st_q.cnt < lim) begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (cfg.clr) begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R6: an accepted failure adds exactly one
    assert_fail_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_pass && cfg.en && lvl == LOCK_NONE)
        |=> cnt == $past(cnt) + ONE);

    // R7: an accepted success with clearing enabled empties the counter
    assert_pass_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pass && cfg.en && cfg.clr && lvl == LOCK_NONE)
        |=> cnt == '0);

    // R3: with the counter disabled results leave it alone
    assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> $stable(cnt));

    // R8: a locked unit ignores results
    assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != LOCK_NONE) |=> $stable(cnt));

    // R8: no result, no change
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(cnt));

endmodule

// File: rtl/pwd_retry_lockout.sv
module pwd_retry_lockout
    import prl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] lim_wdata,
    output logic [CNT_W-1:0] lim_rdata,
    input  logic             res_valid,
    input  logic             res_pass,
    output logic [CNT_W-1:0] fail_cnt,
    output logic [1:0]       lock_lvl
);

    cfg_fields_t      cfg;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt;
    lock_lvl_e        lvl;

    prl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .lim_we    (lim_we),
        .lim_wdata (lim_wdata),
        .cfg       (cfg),
        .cfg_rdata (cfg_rdata),
        .lim       (lim)
    );

    prl_lock_decode #(.CNT_W(CNT_W)) u_decode (
        .cfg (cfg),
        .cnt (cnt),
        .lim (lim),
        .lvl (lvl)
    );

    prl_fail_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .lim       (lim),
        .lvl       (lvl),
        .res_valid (res_valid),
        .res_pass  (res_pass),
        .cnt       (cnt)
    );

    assign lim_rdata = lim;
    assign fail_cnt  = cnt;
    assign lock_lvl  = lvl;

    // R9: the unused level code never reaches the port
    assert_lvl_encoding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lvl != 2'd3);

    // R3: disabled counting means no lockout at the port
    assert_disabled_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[2] |-> lock_lvl == 2'd0);

    // R4: severity 10 at the limit yields total lockout
    assert_total_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && fail_cnt >= lim_rdata && cfg_rdata[7:6] == 2'b10)
        |-> lock_lvl == 2'd2);

    // R5: other severities at the limit yield configuration-only lockout
    assert_cfg_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && fail_cnt >= lim_rdata && cfg_rdata[7:6] != 2'b10)
        |-> lock_lvl == 2'd1);

    // R8: increments alone never lift the count past the limit
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lim_we && fail_cnt <= lim_rdata) |=> fail_cnt <= lim_rdata);

endmodule

// File: tb/pwd_retry_lockout_test.sv
module pwd_retry_lockout_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       lim_we = 1'b0;
    logic [7:0] lim_wdata = '0;
    logic [7:0] lim_rdata;
    logic       res_valid = 1'b0;
    logic       res_pass = 1'b0;
    logic [7:0] fail_cnt;
    logic [1:0] lock_lvl;

    int checks = 0;
    int fails  = 0;

    // model state
    logic       m_s1, m_s0, m_clr, m_en;
    logic [7:0] m_lim, m_cnt;

    always #5 clk = ~clk;

    pwd_retry_lockout uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lim_we(lim_we), .lim_wdata(lim_wdata), .lim_rdata(lim_rdata),
        .res_valid(res_valid), .res_pass(res_pass),
        .fail_cnt(fail_cnt), .lock_lvl(lock_lvl)
    );

    function automatic logic [1:0] m_lvl();
        if (!m_en || m_cnt < m_lim) return 2'd0;
        if ({m_s1, m_s0} == 2'b10) return 2'd2;
        return 2'd1;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [1:0] el;
        string ltag;
        el = m_lvl();
        ltag = (el == 2'd2) ? "R4" : (el == 2'd1) ? "R5" : (m_en ? "R9" : "R3");
        check("R1", "cfg_rdata", cfg_rdata, {m_s1, m_s0, 2'b10, m_clr, m_en, 2'b00});
        check("R2", "lim_rdata", lim_rdata, m_lim);
        check(tag, "fail_cnt", fail_cnt, m_cnt);
        check(ltag, "lock_lvl", lock_lvl, el);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_s1 = 0; m_s0 = 0; m_clr = 0; m_en = 0; m_lim = 0; m_cnt = 0;
    endtask

    task automatic wr_cfg(logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
        m_s1 = v[7]; m_s0 = v[6]; m_clr = v[3]; m_en = v[2];
        check_all("R1");
    endtask

    task automatic wr_lim(logic [7:0] v);
        @(negedge clk);
        lim_we = 1'b1; lim_wdata = v;
        @(negedge clk);
        lim_we = 1'b0; lim_wdata = '0;
        m_lim = v;
        check_all("R2");
    endtask

    task automatic result(logic pass);
        string tag;
        if (!m_en) tag = "R3";
        else if (m_lvl() != 2'd0) tag = "R8";
        else if (pass) tag = "R7";
        else tag = "R6";
        if (m_en && m_lvl() == 2'd0) begin
            if (!pass) begin
                if (m_cnt < m_lim) m_cnt = m_cnt + 8'd1;
            end else if (m_clr) begin
                m_cnt = 8'd0;
            end
        end
        @(negedge clk);
        res_valid = 1'b1; res_pass = pass;
        @(negedge clk);
        res_valid = 1'b0; res_pass = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R2 / R1 reset state
        check("R1", "reset cfg_rdata", cfg_rdata, 8'h20);
        check("R2", "reset lim_rdata", lim_rdata, 0);
        check("R2", "reset fail_cnt", fail_cnt, 0);
        check("R9", "reset lock_lvl", lock_lvl, 0);

        for (int en = 0; en < 2; en++) begin
            for (int clr = 0; clr < 2; clr++) begin
                for (int sev = 0; sev < 4; sev++) begin
                    for (int lim = 0; lim < 4; lim++) begin
                        do_reset();
                        // fixed-position bits written inverted (R1)
                        wr_cfg({sev[1:0], 2'b01, clr[0], en[0], 2'b11});
                        wr_lim(8'(lim));
                        for (int k = 0; k < lim + 2; k++) result(1'b0);
                        result(1'b1);
                        result(1'b0);
                        // raise the limit to unlock, then exercise pass/fail
                        wr_lim(8'(lim + 3));
                        result(1'b0);
                        result(1'b1);
                        result(1'b0);
                        result(1'b0);
                        // drop the limit below the count: at-or-above locks
                        wr_lim(8'd0);
                        result(1'b0);
                        result(1'b1);
                        // disable counting: lockout lifts, results ignored (R3)
                        wr_cfg({sev[1:0], 2'b10, clr[0], 1'b0, 2'b00});
                        result(1'b0);
                        result(1'b1);
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule